// File: doc/BRIEF.md
# Memory Protection Configuration Register Bank

This block stores the software-visible configuration of a bank of physical memory protection entries. Each entry has an 8-bit permission/mode byte and an address register; a single security register carries three global control bits. Software reaches the storage through a flat CSR-style port: a selector picks the configuration group, the address group or the security register; an index picks the register inside that group; a write-enable strobe commits the data on the next clock edge. Read data is combinational from the selector and index.

Writes are filtered before they commit. An entry's lock bit freezes both its byte and its address register. A bypass bit in the security register lifts that freeze, but the bypass bit may only be set from zero while no entry is locked. A locked top-of-range entry also freezes the address register just below it, because that register is its lower bound. When the lockdown bit is set and bypass is clear, four permission codes cannot be written. The lockdown and deny-unmatched bits are sticky. All stored contents leave the block as flat vectors for the range decoder and the access checker. A one-cycle `modified` pulse tells a neighbouring translation cache when it must flush.

Top module: `pmp_csr_bank`

## Requirements
- R1: Configuration byte layout is read at bit 0, write at bit 1, execute at bit 2, match mode at bits 4:3 (0 off, 1 top-of-range, 2 naturally aligned 4-byte, 3 naturally aligned power-of-two), bits 6:5 stored as written, and lock at bit 7. Byte i (bits 8i+7:8i) of configuration register n belongs to entry n*4+i, with XLEN/8 bytes per register. `csr_sel` encodes 0 configuration, 1 address, 2 security, 3 nothing.
- R2: A write to a configuration byte is ignored while that entry's lock bit is set and bypass is clear. With bypass set, the write is accepted.
- R3: While lockdown is set and bypass is clear, a configuration byte whose code {lock,read,write,execute} is 9, 10, 11 or 13 is rejected. Other codes are accepted, subject to R2.
- R4: A write to an address register is ignored while its own entry is locked and bypass is clear.
- R5: A write to address register k is ignored while entry k+1 is locked, is in top-of-range mode and bypass is clear.
- R6: Bypass cannot go from 0 to 1 while any entry is locked. When it is already 1, a write may keep it or clear it.
- R7: Lockdown and deny-unmatched are sticky. Once set, a write cannot clear them.
- R8: Entries at or beyond the implemented count read as zero and ignore writes. This covers a configuration byte or an address index. Selector 3 reads zero and writes nothing.
- R9: `modified` is high for exactly the one cycle after a write edge at which any stored byte, address or security bit changed value. A write of identical contents, or a filtered write, leaves it low.
- R10: Reset clears every register, so all entries start off and unlocked, and `modified` is low.
- R11: The security register reads lockdown at bit 0, deny-unmatched at bit 1 and bypass at bit 2. All other bits read zero and are ignored on write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_sel | input | 2 | Register group: 0 config, 1 address, 2 security, 3 none |
| csr_idx | input | IDX_W | Register index inside the group |
| csr_wdata | input | XLEN | Write data |
| csr_we | input | 1 | Write strobe, commits at the clock edge |
| csr_rdata | output | XLEN | Combinational read data |
| cfg_flat | output | N_ENTRIES*8 | All configuration bytes, entry e at bits 8e+7:8e |
| addr_flat | output | N_ENTRIES*XLEN | All address registers, entry e at slice e |
| lockdown_o | output | 1 | Lockdown bit |
| deny_unmatched_o | output | 1 | Deny-unmatched bit |
| rule_bypass_o | output | 1 | Lock bypass bit |
| modified | output | 1 | One-cycle pulse after any stored value changed |

## Verification
Two filters can meet in one write. A configuration write can touch a locked byte and a lockdown-forbidden code in the same register, so the lock rule and the code rule act on neighbouring bytes in the same cycle. The bench builds such a register value while lockdown is active, then reads the register back byte by byte. It also checks that `modified` reflects only the bytes that were accepted. The random phase mixes writes to the security register with writes that depend on the bypass bit, so bypass changes and the lock filter often act on adjacent cycles. Every result is judged against a bench model that applies the old state's rules before the update.

// File: rtl/pmp_bank_pkg.sv
package pmp_bank_pkg;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_TOR   = 2'd1,
        MODE_NA4   = 2'd2,
        MODE_NAPOT = 2'd3
    } match_mode_e;

    typedef enum logic [1:0] {
        SEL_CFG  = 2'd0,
        SEL_ADDR = 2'd1,
        SEL_SEC  = 2'd2,
        SEL_NONE = 2'd3
    } csr_sel_e;

    typedef struct packed {
        logic        lock;
        logic [1:0]  spare;
        match_mode_e mode;
        logic        x;
        logic        w;
        logic        r;
    } pmp_cfg_t;

    typedef struct packed {
        logic rule_bypass;
        logic deny_unmatched;
        logic lockdown;
    } sec_cfg_t;

    function automatic logic [3:0] perm_code(pmp_cfg_t c);
        return {c.lock, c.r, c.w, c.x};
    endfunction

    function automatic logic lockdown_forbidden(pmp_cfg_t c);
        logic [3:0] k;
        k = perm_code(c);
        return (k == 4'd9) || (k == 4'd10) || (k == 4'd11) || (k == 4'd13);
    endfunction

    function automatic logic write_frozen(pmp_cfg_t c, logic bypass);
        return c.lock & ~bypass;
    endfunction

endpackage

// File: rtl/pmp_entry_slot.sv
module pmp_entry_slot
    import pmp_bank_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_we,
    input  pmp_cfg_t        cfg_wbyte,
    input  logic            addr_we,
    input  logic [XLEN-1:0] addr_wval,
    input  logic            bypass,
    input  logic            lockdown,
    input  logic            next_tor_locked,
    output pmp_cfg_t        cfg_q,
    output logic [XLEN-1:0] addr_q,
    output logic            changed
);
    pmp_cfg_t        cfg_d;
    logic [XLEN-1:0] addr_d;
    logic            frozen;
    logic            code_blocked;
    logic            bound_blocked;

    always_comb begin
        frozen        = write_frozen(cfg_q, bypass);
        code_blocked  = lockdown && !bypass && lockdown_forbidden(cfg_wbyte);
        bound_blocked = next_tor_locked && !bypass;
        cfg_d  = cfg_q;
        addr_d = addr_q;
        if (cfg_we && !frozen && !code_blocked) begin
            cfg_d = cfg_wbyte;
        end
        if (addr_we && !frozen && !bound_blocked) begin
            addr_d = addr_wval;
        end
        changed = (cfg_d != cfg_q) || (addr_d != addr_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            addr_q <= '0;
        end else begin
            cfg_q  <= cfg_d;
            addr_q <= addr_d;
        end
    end
endmodule

// File: rtl/pmp_sec_reg.sv
module pmp_sec_reg
    import pmp_bank_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     we,
    input  sec_cfg_t wval,
    input  logic     any_lock,
    output sec_cfg_t sec_q,
    output logic     changed
);
    sec_cfg_t sec_d;

    always_comb begin
        sec_d = sec_q;
        if (we) begin
            sec_d.lockdown       = sec_q.lockdown | wval.lockdown;
            sec_d.deny_unmatched = sec_q.deny_unmatched | wval.deny_unmatched;
            sec_d.rule_bypass    = wval.rule_bypass & (sec_q.rule_bypass | ~any_lock);
        end
        changed = (sec_d != sec_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_q <= '0;
        end else begin
            sec_q <= sec_d;
        end
    end
endmodule

// File: rtl/pmp_csr_readmux.sv
module pmp_csr_readmux
    import pmp_bank_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    parameter int XLEN      = 32,
    parameter int IDX_W     = 5
) (
    input  logic [1:0]                      sel,
    input  logic [IDX_W-1:0]                idx,
    input  pmp_cfg_t [N_ENTRIES-1:0]        cfg_q,
    input  logic [N_ENTRIES-1:0][XLEN-1:0]  addr_q,
    input  sec_cfg_t                        sec_q,
    output logic [XLEN-1:0]                 rdata
);
    localparam int BPC   = XLEN / 8;
    localparam int ENT_W = IDX_W + 3;
    localparam int EIDX  = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;

    logic [ENT_W-1:0] base;
    logic [ENT_W-1:0] tgt;

    always_comb begin
        rdata = '0;
        base  = ENT_W'({idx, 2'b00});
        tgt   = '0;
        case (csr_sel_e'(sel))
            SEL_CFG: begin
                for (int i = 0; i < BPC; i++) begin
                    tgt = base + ENT_W'(i);
                    if (tgt < ENT_W'(N_ENTRIES)) begin
                        rdata[8*i +: 8] = cfg_q[tgt[EIDX-1:0]];
                    end
                end
            end
            SEL_ADDR: begin
                tgt = ENT_W'(idx);
                if (tgt < ENT_W'(N_ENTRIES)) begin
                    rdata = addr_q[tgt[EIDX-1:0]];
                end
            end
            SEL_SEC:  rdata[2:0] = sec_q;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/pmp_csr_bank.sv
module pmp_csr_bank
    import pmp_bank_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    parameter int XLEN      = 32,
    parameter int IDX_W     = 5
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [1:0]                csr_sel,
    input  logic [IDX_W-1:0]          csr_idx,
    input  logic [XLEN-1:0]           csr_wdata,
    input  logic                      csr_we,
    output logic [XLEN-1:0]           csr_rdata,
    output logic [N_ENTRIES*8-1:0]    cfg_flat,
    output logic [N_ENTRIES*XLEN-1:0] addr_flat,
    output logic                      lockdown_o,
    output logic                      deny_unmatched_o,
    output logic                      rule_bypass_o,
    output logic                      modified
);
    localparam int BPC   = XLEN / 8;
    localparam int ENT_W = IDX_W + 3;

    pmp_cfg_t [N_ENTRIES-1:0]        cfg_q;
    pmp_cfg_t [N_ENTRIES-1:0]        cfg_wbyte;
    logic [N_ENTRIES-1:0][XLEN-1:0]  addr_q;
    logic [N_ENTRIES-1:0]            cfg_hit;
    logic [N_ENTRIES-1:0]            addr_hit;
    logic [N_ENTRIES-1:0]            next_guard;
    logic [N_ENTRIES-1:0]            lock_vec;
    logic [N_ENTRIES-1:0]            slot_changed;
    logic [ENT_W-1:0]                base;
    sec_cfg_t                        sec_q;
    logic                            sec_changed;
    logic                            sec_we;

    always_comb begin
        base = ENT_W'({csr_idx, 2'b00});
        for (int e = 0; e < N_ENTRIES; e++) begin
            cfg_hit[e]   = 1'b0;
            cfg_wbyte[e] = '0;
            addr_hit[e]  = csr_we && (csr_sel_e'(csr_sel) == SEL_ADDR)
                           && (ENT_W'(csr_idx) == ENT_W'(e));
            for (int i = 0; i < BPC; i++) begin
                if (csr_we && (csr_sel_e'(csr_sel) == SEL_CFG)
                    && (base + ENT_W'(i) == ENT_W'(e))) begin
                    cfg_hit[e]   = 1'b1;
                    cfg_wbyte[e] = pmp_cfg_t'(csr_wdata[8*i +: 8]);
                end
            end
        end
        sec_we = csr_we && (csr_sel_e'(csr_sel) == SEL_SEC);
    end

    for (genvar e = 0; e < N_ENTRIES; e++) begin : g_slot
        if (e == N_ENTRIES - 1) begin : g_last
            assign next_guard[e] = 1'b0;
        end else begin : g_mid
            assign next_guard[e] = cfg_q[e+1].lock && (cfg_q[e+1].mode == MODE_TOR);
        end

        assign lock_vec[e]                 = cfg_q[e].lock;
        assign cfg_flat[8*e +: 8]          = cfg_q[e];
        assign addr_flat[XLEN*e +: XLEN]   = addr_q[e];

        pmp_entry_slot #(.XLEN(XLEN)) u_slot (
            .clk            (clk),
            .rst            (rst),
            .cfg_we         (cfg_hit[e]),
            .cfg_wbyte      (cfg_wbyte[e]),
            .addr_we        (addr_hit[e]),
            .addr_wval      (csr_wdata),
            .bypass         (sec_q.rule_bypass),
            .lockdown       (sec_q.lockdown),
            .next_tor_locked(next_guard[e]),
            .cfg_q          (cfg_q[e]),
            .addr_q         (addr_q[e]),
            .changed        (slot_changed[e])
        );
    end

    pmp_sec_reg u_sec (
        .clk     (clk),
        .rst     (rst),
        .we      (sec_we),
        .wval    (sec_cfg_t'(csr_wdata[2:0])),
        .any_lock(|lock_vec),
        .sec_q   (sec_q),
        .changed (sec_changed)
    );

    pmp_csr_readmux #(
        .N_ENTRIES(N_ENTRIES),
        .XLEN     (XLEN),
        .IDX_W    (IDX_W)
    ) u_rd (
        .sel   (csr_sel),
        .idx   (csr_idx),
        .cfg_q (cfg_q),
        .addr_q(addr_q),
        .sec_q (sec_q),
        .rdata (csr_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            modified <= 1'b0;
        end else begin
            modified <= (|slot_changed) | sec_changed;
        end
    end

    assign lockdown_o       = sec_q.lockdown;
    assign deny_unmatched_o = sec_q.deny_unmatched;
    assign rule_bypass_o    = sec_q.rule_bypass;
endmodule

// File: rtl/pmp_csr_bank_chk.sv
module pmp_csr_bank_chk
    import pmp_bank_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    parameter int XLEN      = 32
) (
    input logic                      clk,
    input logic                      rst,
    input logic [N_ENTRIES*8-1:0]    cfg_flat,
    input logic [N_ENTRIES*XLEN-1:0] addr_flat,
    input logic                      lockdown_o,
    input logic                      deny_unmatched_o,
    input logic                      rule_bypass_o,
    input logic                      modified
);
    logic [N_ENTRIES-1:0] locks;
    for (genvar e = 0; e < N_ENTRIES; e++) begin : g_lk
        assign locks[e] = cfg_flat[8*e + 7];
    end

    for (genvar e = 0; e < N_ENTRIES; e++) begin : g_ent
        p_cfg_frozen_r2: assert property (@(posedge clk) disable iff (rst)
            $past(cfg_flat[8*e+7] && !rule_bypass_o)
            |-> cfg_flat[8*e +: 8] == $past(cfg_flat[8*e +: 8]));

        p_addr_frozen_r4: assert property (@(posedge clk) disable iff (rst)
            $past(cfg_flat[8*e+7] && !rule_bypass_o)
            |-> addr_flat[XLEN*e +: XLEN] == $past(addr_flat[XLEN*e +: XLEN]));

        p_lockdown_code_r3: assert property (@(posedge clk) disable iff (rst)
            ($past(lockdown_o && !rule_bypass_o)
             && cfg_flat[8*e +: 8] != $past(cfg_flat[8*e +: 8]))
            |-> !lockdown_forbidden(pmp_cfg_t'(cfg_flat[8*e +: 8])));

        if (e < N_ENTRIES - 1) begin : g_tor
            p_tor_bound_r5: assert property (@(posedge clk) disable iff (rst)
                $past(cfg_flat[8*(e+1)+7] && cfg_flat[8*(e+1)+4 -: 2] == 2'd1
                      && !rule_bypass_o)
                |-> addr_flat[XLEN*e +: XLEN] == $past(addr_flat[XLEN*e +: XLEN]));
        end
    end

    p_sticky_lockdown_r7: assert property (@(posedge clk) disable iff (rst)
        $past(lockdown_o) |-> lockdown_o);

    p_sticky_deny_r7: assert property (@(posedge clk) disable iff (rst)
        $past(deny_unmatched_o) |-> deny_unmatched_o);

    p_bypass_set_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rule_bypass_o) && $past(|locks)) |-> !rule_bypass_o);

    p_mod_change_r9: assert property (@(posedge clk) disable iff (rst)
        modified == ((cfg_flat != $past(cfg_flat)) || (addr_flat != $past(addr_flat))
                     || ({rule_bypass_o, deny_unmatched_o, lockdown_o}
                         != $past({rule_bypass_o, deny_unmatched_o, lockdown_o}))));
endmodule

bind pmp_csr_bank pmp_csr_bank_chk #(
    .N_ENTRIES(N_ENTRIES),
    .XLEN     (XLEN)
) u_chk (
    .clk             (clk),
    .rst             (rst),
    .cfg_flat        (cfg_flat),
    .addr_flat       (addr_flat),
    .lockdown_o      (lockdown_o),
    .deny_unmatched_o(deny_unmatched_o),
    .rule_bypass_o   (rule_bypass_o),
    .modified        (modified)
);

// File: tb/pmp_csr_bank_test.sv
`timescale 1ns/1ps
module pmp_csr_bank_test;
    localparam int N     = 16;
    localparam int XLEN  = 32;
    localparam int IDX_W = 5;
    localparam int BPC   = XLEN / 8;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [1:0]         csr_sel = 2'd3;
    logic [IDX_W-1:0]   csr_idx = '0;
    logic [XLEN-1:0]    csr_wdata = '0;
    logic               csr_we = 1'b0;
    logic [XLEN-1:0]    csr_rdata;
    logic [N*8-1:0]     cfg_flat;
    logic [N*XLEN-1:0]  addr_flat;
    logic               lockdown_o, deny_unmatched_o, rule_bypass_o, modified;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0]      m_cfg [N];
    logic [XLEN-1:0] m_addr[N];
    logic [2:0]      m_sec;   // bit0 lockdown, bit1 deny-unmatched, bit2 bypass

    always #4 clk = ~clk;

    pmp_csr_bank #(.N_ENTRIES(N), .XLEN(XLEN), .IDX_W(IDX_W)) uut (
        .clk(clk), .rst(rst), .csr_sel(csr_sel), .csr_idx(csr_idx),
        .csr_wdata(csr_wdata), .csr_we(csr_we), .csr_rdata(csr_rdata),
        .cfg_flat(cfg_flat), .addr_flat(addr_flat), .lockdown_o(lockdown_o),
        .deny_unmatched_o(deny_unmatched_o), .rule_bypass_o(rule_bypass_o),
        .modified(modified)
    );

    task automatic check_eq(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit m_bad_code(logic [7:0] b);
        logic [3:0] c;
        c = {b[7], b[0], b[1], b[2]};
        return (c == 4'd9) || (c == 4'd10) || (c == 4'd11) || (c == 4'd13);
    endfunction

    task automatic model_clear();
        for (int e = 0; e < N; e++) begin
            m_cfg[e] = '0;
            m_addr[e] = '0;
        end
        m_sec = '0;
    endtask

    task automatic model_write(logic [1:0] sel, int idx, logic [XLEN-1:0] d, output bit ch);
        logic [7:0] oc[N];
        bit byp, anyl;
        ch = 0;
        for (int e = 0; e < N; e++) oc[e] = m_cfg[e];
        byp = m_sec[2];
        anyl = 0;
        for (int e = 0; e < N; e++) if (oc[e][7]) anyl = 1;
        if (sel == 2'd0) begin
            for (int i = 0; i < BPC; i++) begin
                int e = idx * 4 + i;
                logic [7:0] b = d[8*i +: 8];
                if (e < N && !(oc[e][7] && !byp) && !(m_sec[0] && !byp && m_bad_code(b))) begin
                    if (b != m_cfg[e]) ch = 1;
                    m_cfg[e] = b;
                end
            end
        end else if (sel == 2'd1) begin
            if (idx < N) begin
                bit guard = (idx + 1 < N) && oc[idx+1][7] && !byp && (oc[idx+1][4:3] == 2'd1);
                if (!guard && !(oc[idx][7] && !byp)) begin
                    if (d != m_addr[idx]) ch = 1;
                    m_addr[idx] = d;
                end
            end
        end else if (sel == 2'd2) begin
            logic [2:0] nv;
            nv[0] = m_sec[0] | d[0];
            nv[1] = m_sec[1] | d[1];
            nv[2] = d[2] && (m_sec[2] || !anyl);
            if (nv != m_sec) ch = 1;
            m_sec = nv;
        end
    endtask

    function automatic logic [XLEN-1:0] model_read(logic [1:0] sel, int idx);
        logic [XLEN-1:0] r = '0;
        if (sel == 2'd0) begin
            for (int i = 0; i < BPC; i++)
                if (idx * 4 + i < N) r[8*i +: 8] = m_cfg[idx*4+i];
        end else if (sel == 2'd1) begin
            if (idx < N) r = m_addr[idx];
        end else if (sel == 2'd2) begin
            r[2:0] = m_sec;
        end
        return r;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        csr_we = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    // R9 is judged on every write: modified follows the write edge by one register
    task automatic do_write(logic [1:0] sel, int idx, logic [XLEN-1:0] d);
        bit ch;
        @(negedge clk);
        csr_sel = sel;
        csr_idx = IDX_W'(idx);
        csr_wdata = d;
        csr_we = 1'b1;
        @(negedge clk);
        csr_we = 1'b0;
        model_write(sel, idx, d, ch);
        check_eq("R9 modified", XLEN'(modified), XLEN'(ch));
    endtask

    task automatic read_exp(string req, logic [1:0] sel, int idx, logic [XLEN-1:0] exp);
        @(negedge clk);
        csr_sel = sel;
        csr_idx = IDX_W'(idx);
        #1;
        check_eq(req, csr_rdata, exp);
        check_eq(req, csr_rdata, model_read(sel, idx));
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hang expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        model_clear();
        do_reset();

        // R10: reset state
        read_exp("R10 cfg0", 2'd0, 0, 32'h0);
        read_exp("R10 addr0", 2'd1, 0, 32'h0);
        read_exp("R10 sec", 2'd2, 0, 32'h0);
        check_eq("R10 modified", XLEN'(modified), 0);
        check_eq("R10 cfg_flat", XLEN'(cfg_flat[31:0]), 0);

        // R1: byte packing, register 1 covers entries 4..7
        do_write(2'd0, 1, 32'h0B1A0908);
        read_exp("R1 cfg1", 2'd0, 1, 32'h0B1A0908);
        check_eq("R1 entry5", XLEN'(cfg_flat[5*8 +: 8]), 32'h09);
        check_eq("R1 entry7", XLEN'(cfg_flat[7*8 +: 8]), 32'h0B);
        // R9: identical write, no pulse
        do_write(2'd0, 1, 32'h0B1A0908);
        check_eq("R9 same", XLEN'(modified), 0);

        // R11: only bits 2:0 of the security register stored
        do_write(2'd2, 0, 32'hFFFFFFF4);
        read_exp("R11 sec", 2'd2, 0, 32'h4);

        // R2: writes under bypass, then frozen
        do_write(2'd0, 0, 32'h00000080);
        do_write(2'd0, 0, 32'h00000081);
        read_exp("R2 bypass write", 2'd0, 0, 32'h00000081);
        do_write(2'd2, 0, 32'h0);
        do_write(2'd0, 0, 32'h00000003);
        read_exp("R2 locked", 2'd0, 0, 32'h00000081);
        check_eq("R2 no pulse", XLEN'(modified), 0);

        // R6: bypass refused while an entry is locked
        do_write(2'd2, 0, 32'h4);
        read_exp("R6 sec", 2'd2, 0, 32'h0);

        // R4: own lock freezes address
        do_write(2'd1, 0, 32'h0000_1111);
        read_exp("R4 addr0", 2'd1, 0, 32'h0);

        // R5: entry 3 locked top-of-range guards address 2
        do_write(2'd0, 0, 32'h88000081);
        read_exp("R5 cfg0", 2'd0, 0, 32'h88000081);
        do_write(2'd1, 2, 32'h0000_1234);
        read_exp("R5 addr2", 2'd1, 2, 32'h0);
        do_write(2'd1, 1, 32'h0000_5678);
        read_exp("R5 addr1", 2'd1, 1, 32'h0000_5678);

        // R8: out-of-range entries
        do_write(2'd0, 4, 32'hFFFFFFFF);
        read_exp("R8 cfg4", 2'd0, 4, 32'h0);
        do_write(2'd1, 20, 32'hDEADBEEF);
        read_exp("R8 addr20", 2'd1, 20, 32'h0);
        do_write(2'd3, 0, 32'hFFFFFFFF);
        read_exp("R8 sel3", 2'd3, 0, 32'h0);

        // R7: sticky bits
        do_write(2'd2, 0, 32'h3);
        do_write(2'd2, 0, 32'h0);
        read_exp("R7 sticky", 2'd2, 0, 32'h3);

        // R3 with R2: forbidden codes rejected bytewise (9 and 11), codes 14 and 5 kept
        do_write(2'd0, 2, 32'h86058384);
        read_exp("R3 cfg2", 2'd0, 2, 32'h00058300);

        // random phase against the model
        for (int blk = 0; blk < 6; blk++) begin
            do_reset();
            for (int k = 0; k < 300; k++) begin
                int op = $urandom % 10;
                logic [XLEN-1:0] d = $urandom;
                if (op < 5) begin
                    for (int i = 0; i < BPC; i++) begin
                        d[8*i+7] = ($urandom % 10) == 0;
                    end
                    do_write(2'd0, $urandom % 6, d);
                end else if (op < 8) begin
                    do_write(2'd1, $urandom % 20, d);
                end else begin
                    d[0] = ($urandom % 6) == 0;
                    d[1] = ($urandom % 6) == 0;
                    do_write(2'd2, 0, d);
                end
                begin
                    logic [1:0] rs = 2'($urandom % 4);
                    int ri = (rs == 2'd0) ? int'($urandom % 6) : int'($urandom % 20);
                    @(negedge clk);
                    csr_sel = rs;
                    csr_idx = IDX_W'(ri);
                    #1;
                    check_eq("R1 R8 random read", csr_rdata, model_read(rs, ri));
                end
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule